// File: doc/BRIEF.md
# Power Mode Sequencer With Undervoltage Lockout

This block decides which operating mode a smart high-side switch is in: normal (output driven, all internal blocks biased), plain standby (everything unbiased), or standby with diagnostics (output off, diagnostic circuits biased). It watches the switch command pin, the diagnostic-request pin and a digitised supply voltage. It produces the current mode, a bias-enable that gates the internal blocks, and a global shutdown flag.

Entering normal mode is immediate whenever the switch command is high. Leaving normal mode is deglitched: the command must stay low for a programmable number of clocks (3 ms worth of clocks by default). Only then does the block drop into plain standby or diagnostic standby, chosen by the diagnostic request. Between the two standby states the diagnostic request acts at once. A hysteretic supply comparator and a ground-loss input override every mode: they hold shutdown high and bias low, while the mode register follows the mode the pins imply. When the override clears, operation resumes from that mode. The supply arrives as an unsigned code in 100 mV steps.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is held, and one clock after it, the outputs read mode_o = 2'b00 (standby), bias_en_o = 0 and shutdown_o = 1. Mode codes: 2'b00 standby, 2'b01 diagnostic standby, 2'b10 normal.
- R2: When not halted, in_ctl sampled high at a clock edge puts mode_o at 2'b10 after that edge. This holds from either standby state.
- R3: In normal mode, in_ctl sampled low on DWELL_CYC consecutive edges leaves normal mode at the last of those edges. The new mode is 2'b01 if diag_req is high at that edge, else 2'b00.
- R4: An in_ctl low pulse shorter than DWELL_CYC edges leaves mode_o at 2'b10. The count restarts, so a later low stretch again needs the full DWELL_CYC edges.
- R5: When not halted and in_ctl is low, the mode moves 2'b00 to 2'b01 at the first edge that samples diag_req high. It moves 2'b01 to 2'b00 at the first edge that samples diag_req low.
- R6: The lockout asserts at an edge where vs_code <= UV_FALL and releases at an edge where vs_code >= UV_RISE. Between the two thresholds it keeps its state. It starts asserted after reset. shutdown_o shows the lockout (ORed with ground loss) right after that edge.
- R7: While halted, bias_en_o is 0 and mode_o follows the pins with no deglitch: 2'b10 if in_ctl is high, else 2'b01 if diag_req is high, else 2'b00. After release the block continues from that mode.
- R8: gnd_loss sampled high forces shutdown_o = 1 and bias_en_o = 0 after that edge, regardless of in_ctl.
- R9: When not halted, bias_en_o is 1 in modes 2'b10 and 2'b01 and 0 in mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ctl | input | 1 | Switch command (high = turn on) |
| diag_req | input | 1 | Diagnostic request |
| vs_code | input | VCODE_W | Supply voltage code, 100 mV per step |
| gnd_loss | input | 1 | Ground-loss indication, forces shutdown |
| mode_o | output | 2 | Current mode |
| bias_en_o | output | 1 | Bias enable for internal blocks |
| shutdown_o | output | 1 | Global shutdown (lockout or ground loss) |

## Verification
The switch command is driven with low pulses one cycle short of the deglitch window, exactly the window long, and long stretches. This separates an off-by-one in the counter from a missing restart after a glitch. The diagnostic request is toggled in standby and at the moment the deglitch expires, to show that the choice of target state is made at the exit edge. The supply code is swept through the band between the thresholds in both directions to tell true hysteresis from a single threshold. Lockout and ground loss are applied with the command high, to show that the mode tracks the pins while bias stays off and that operation resumes cleanly.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    PM_STBY = 2'b00,
    PM_DIAG = 2'b01,
    PM_NORM = 2'b10
  } pm_mode_t;

  function automatic pm_mode_t pm_implied(input logic in_v, input logic diag_v);
    if (in_v)        return PM_NORM;
    else if (diag_v) return PM_DIAG;
    else             return PM_STBY;
  endfunction
endpackage

// File: rtl/pms_uvlo.sv
module pms_uvlo #(
  parameter int VCODE_W = 6,
  parameter int UV_FALL = 32,
  parameter int UV_RISE = 37
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VCODE_W-1:0] code_i,
  output logic               lock_d_o
);
  localparam logic [VCODE_W-1:0] FALL_C = VCODE_W'(UV_FALL);
  localparam logic [VCODE_W-1:0] RISE_C = VCODE_W'(UV_RISE);

  logic lock_q;

  always_comb begin
    if (lock_q) lock_d_o = (code_i < RISE_C);
    else        lock_d_o = (code_i <= FALL_C);
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b1;
    else     lock_q <= lock_d_o;
  end

  // R6
  hold_released_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && code_i > FALL_C) |=> !lock_q);
  // R6
  hold_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && code_i < RISE_C) |=> lock_q);
endmodule

// File: rtl/pms_dwell.sv
module pms_dwell #(
  parameter int DWELL_CYC = 375000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(DWELL_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !step_i || expired_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_i,
  input  logic     diag_i,
  input  logic     halt_d_i,
  input  logic     expired_i,
  output logic     step_o,
  output pm_mode_t state_q,
  output logic     bias_q
);
  pm_mode_t state_d;
  logic     bias_d;

  always_comb begin
    state_d = state_q;
    if (halt_d_i) begin
      state_d = pm_implied(in_i, diag_i);
    end else begin
      case (state_q)
        PM_STBY: if (in_i) state_d = PM_NORM;
                 else if (diag_i) state_d = PM_DIAG;
        PM_DIAG: if (in_i) state_d = PM_NORM;
                 else if (!diag_i) state_d = PM_STBY;
        PM_NORM: if (expired_i) state_d = diag_i ? PM_DIAG : PM_STBY;
        default: state_d = PM_STBY;
      endcase
    end
    bias_d = !halt_d_i && (state_d != PM_STBY);
    step_o = (state_q == PM_NORM) && !in_i && !halt_d_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_STBY;
      bias_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bias_q  <= bias_d;
    end
  end

  // R2
  enter_norm_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt_d_i && in_i) |=> state_q == PM_NORM);
  // R4
  glitch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_NORM && !halt_d_i && !expired_i) |=> state_q == PM_NORM);
  // R5
  diag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STBY && !halt_d_i && !in_i && diag_i) |=> state_q == PM_DIAG);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int VCODE_W   = 6,
  parameter int UV_FALL   = 32,
  parameter int UV_RISE   = 37,
  parameter int DWELL_CYC = 375000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_ctl,
  input  logic               diag_req,
  input  logic [VCODE_W-1:0] vs_code,
  input  logic               gnd_loss,
  output logic [1:0]         mode_o,
  output logic               bias_en_o,
  output logic               shutdown_o
);
  logic     uv_d, halt_d, step, expired;
  pm_mode_t state;

  pms_uvlo #(.VCODE_W(VCODE_W), .UV_FALL(UV_FALL), .UV_RISE(UV_RISE)) u_uvlo (
    .clk(clk), .rst(rst), .code_i(vs_code), .lock_d_o(uv_d));

  assign halt_d = uv_d | gnd_loss;

  pms_dwell #(.DWELL_CYC(DWELL_CYC)) u_dwell (
    .clk(clk), .rst(rst), .step_i(step), .expired_o(expired));

  pms_fsm u_fsm (
    .clk(clk), .rst(rst), .in_i(in_ctl), .diag_i(diag_req),
    .halt_d_i(halt_d), .expired_i(expired), .step_o(step),
    .state_q(state), .bias_q(bias_en_o));

  always_ff @(posedge clk) begin
    if (rst) shutdown_o <= 1'b1;
    else     shutdown_o <= halt_d;
  end

  assign mode_o = state;

  // R7
  halt_bias_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> !bias_en_o);
  // R8
  gnd_off_chk: assert property (@(posedge clk) disable iff (rst)
    gnd_loss |=> shutdown_o);
endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int VW = 6;
  localparam int FALL = 32;
  localparam int RISE = 37;
  localparam int DG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_ctl = 1'b0, diag_req = 1'b0, gnd_loss = 1'b0;
  logic [VW-1:0] vs_code = 6'd50;
  logic [1:0] mode_o;
  logic bias_en_o, shutdown_o;

  pwr_mode_seq #(.VCODE_W(VW), .UV_FALL(FALL), .UV_RISE(RISE), .DWELL_CYC(DG)) dut (
    .clk(clk), .rst(rst), .in_ctl(in_ctl), .diag_req(diag_req), .vs_code(vs_code),
    .gnd_loss(gnd_loss), .mode_o(mode_o), .bias_en_o(bias_en_o), .shutdown_o(shutdown_o));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int m_mode, m_cnt;
  bit m_bias, m_shdn, m_uv;
  always @(posedge clk) begin
    bit uvn, halt;
    if (rst) begin
      m_mode = 0; m_bias = 0; m_shdn = 1; m_uv = 1; m_cnt = 0;
    end else begin
      if (m_uv) uvn = !(vs_code >= RISE); else uvn = (vs_code <= FALL);
      halt = uvn || gnd_loss;
      if (halt) begin
        m_mode = in_ctl ? 2 : (diag_req ? 1 : 0);
        m_cnt = 0;
      end else if (m_mode == 2) begin
        if (in_ctl) m_cnt = 0;
        else begin
          m_cnt++;
          if (m_cnt == DG) begin m_mode = diag_req ? 1 : 0; m_cnt = 0; end
        end
      end else if (in_ctl) begin
        m_mode = 2; m_cnt = 0;
      end else m_mode = diag_req ? 1 : 0;
      m_bias = !halt && m_mode != 0;
      m_shdn = halt;
      m_uv = uvn;
    end
  end

  task automatic chk(string t, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({tag, " mode"}, int'(mode_o), m_mode);
    chk({tag, " bias"}, int'(bias_en_o), int'(m_bias));
    chk({tag, " shutdown"}, int'(shutdown_o), int'(m_shdn));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tag = "R1";
    ticks(3);
    chk("R1 mode in reset", int'(mode_o), 0);
    chk("R1 shutdown in reset", int'(shutdown_o), 1);
    rst = 1'b0;
    tick();
    chk("R1 bias after reset", int'(bias_en_o), 0);
    chk("R6 release at good supply", int'(shutdown_o), 0);

    // R5 / R9 standby <-> diagnostic standby
    tag = "R5";
    diag_req = 1; tick();
    chk("R5 diag rise", int'(mode_o), 1);
    chk("R9 bias in diag standby", int'(bias_en_o), 1);
    diag_req = 0; tick();
    chk("R5 diag fall", int'(mode_o), 0);
    chk("R9 bias in standby", int'(bias_en_o), 0);
    ticks(2);

    // R2 enter normal
    tag = "R2";
    in_ctl = 1; tick();
    chk("R2 normal from standby", int'(mode_o), 2);
    chk("R9 bias in normal", int'(bias_en_o), 1);
    ticks(2);

    // R4 glitches shorter than window
    tag = "R4";
    in_ctl = 0; ticks(DG - 1);
    in_ctl = 1; tick();
    chk("R4 glitch DG-1 stays normal", int'(mode_o), 2);
    in_ctl = 0; ticks(5);
    in_ctl = 1; tick();
    in_ctl = 0; ticks(DG - 1);
    chk("R4 timer restarted", int'(mode_o), 2);

    // R3 exit to diagnostic standby
    tag = "R3";
    diag_req = 1; tick();
    chk("R3 exit to diag", int'(mode_o), 1);
    ticks(2);
    in_ctl = 1; tick();
    chk("R2 normal from diag", int'(mode_o), 2);
    diag_req = 0;
    in_ctl = 0; ticks(DG);
    chk("R3 exit to standby", int'(mode_o), 0);
    ticks(3);

    // R6 / R7 undervoltage hysteresis
    tag = "R6";
    in_ctl = 1; tick();
    vs_code = 6'd33; ticks(3);
    chk("R6 above fall threshold holds", int'(shutdown_o), 0);
    vs_code = 6'd32; tick();
    chk("R6 lock at fall", int'(shutdown_o), 1);
    tag = "R7";
    chk("R7 bias off while locked", int'(bias_en_o), 0);
    chk("R7 mode follows pins", int'(mode_o), 2);
    vs_code = 6'd36; ticks(3);
    chk("R6 below rise holds lock", int'(shutdown_o), 1);
    in_ctl = 0; diag_req = 1; tick();
    chk("R7 no deglitch while locked", int'(mode_o), 1);
    in_ctl = 1; diag_req = 0; tick();
    vs_code = 6'd37; tick();
    chk("R6 release at rise", int'(shutdown_o), 0);
    chk("R7 resume normal bias", int'(bias_en_o), 1);
    ticks(2);

    // R8 ground loss
    tag = "R8";
    gnd_loss = 1; tick();
    chk("R8 shutdown on ground loss", int'(shutdown_o), 1);
    chk("R8 bias off", int'(bias_en_o), 0);
    ticks(2);
    gnd_loss = 0; tick();
    chk("R8 recover", int'(shutdown_o), 0);
    in_ctl = 0; ticks(DG + 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule